// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR memory interface and takes the memory from the moment reset is released to the point where ordinary traffic may begin. It holds clock enable low for a settling period and then raises it with a no-operation command. After that it walks a fixed list of commands: precharge of every bank, a write of the extended mode register that turns the delay-locked loop on, a mode register write that resets that loop, a second precharge of every bank, a configurable number of auto refreshes, and a last mode register write with the loop reset bit cleared. Between commands it inserts the no-operation gaps each command needs.

The desired read latency, burst length and burst ordering enter as plain numbers and a flag. The block turns them into the mode register word. A busy flag stays high until the sequence is complete, and a done flag then rises and stays up. A separate read permission flag rises only once the loop has had its lock time after the reset write and the sequence has also finished. Every wait length is a module parameter counted in clock cycles.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and for exactly T_STABLE cycles after it is released, mem_cke is 0 and the command bus carries NOP (cs_n, ras_n, cas_n, we_n = 0,1,1,1); init_busy is 1, init_done and rd_ok are 0.
- R2: mem_cke then rises and stays high until the next reset. The cycle in which it rises carries NOP, so clock enable is high for at least one cycle before the first mode register write.
- R3: After clock enable rises, exactly seven commands appear, in this order: precharge all, extended mode write, mode write with loop reset, precharge all, refresh, refresh, mode write. The encodings of {cs_n,ras_n,cas_n,we_n} are precharge 0010, refresh 0001 and mode write 0000.
- R4: Both precharge commands drive address bit 8 high, so that all banks are selected.
- R5: The extended mode write drives bank address 01 and an all-zero address, with bit 0 = 0 so that the loop is enabled.
- R6: Both mode writes drive bank address 00. In the address, bits 2:0 carry the burst length (2→001, 4→010, 8→011), bit 3 the ordering (0 sequential, 1 interleaved), bits 6:4 the read latency (3→011, 4→100), and bits 7 and 9 are 0. Bit 8 is 1 in the first mode write and 0 in the last.
- R7: A latency input other than 3 or 4 is encoded as latency 3. A burst length input other than 2, 4 or 8 is encoded as length 4.
- R8: After a mode write exactly T_MRD NOP cycles follow, after a precharge exactly T_RP, and after a refresh exactly T_RFC, before the next command. The first precharge comes in the cycle right after the clock enable rise.
- R9: init_done rises in the cycle after the T_MRD NOPs that follow the final mode write, and stays high. init_busy is its inverse at all times. After done, the bus carries NOP with clock enable high.
- R10: rd_ok rises in the later of two cycles: the one where init_done rises, and the one that lies T_DLL cycles after the loop-reset mode write. It stays high after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | Desired read latency in cycles (3 or 4) |
| cfg_burst_len | input | 4 | Desired burst length (2, 4 or 8) |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address / mode word |
| init_busy | output | 1 | High while the sequence runs |
| init_done | output | 1 | Sequence complete |
| rd_ok | output | 1 | Reads permitted (loop locked and sequence complete) |

## Verification
The bound checker watches every cycle for the timing rules that concern a single cycle or a short window. It checks that the bus is quiet while clock enable is low, that clock enable never drops once raised, and that clock enable was high before any mode write. It also checks the minimum NOP gap behind each kind of command, that read permission never comes earlier than the lock count allows or before done, and that done is held with a quiet bus. Only the bench scenarios can show the complete command order, the exact mode words for each configuration, including the reserved inputs, and the exact cycles in which done and read permission rise. The bench also restarts the sequence through a reset taken partway through a run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_CKE_UP,
        ST_PRE_A,
        ST_PRE_A_W,
        ST_EMR,
        ST_EMR_W,
        ST_MR_RST,
        ST_MR_RST_W,
        ST_PRE_B,
        ST_PRE_B_W,
        ST_REF,
        ST_REF_W,
        ST_MR_RUN,
        ST_MR_RUN_W,
        ST_READY
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    localparam int ALLBANK_BIT = 8;
    localparam int DLLRST_BIT  = 8;

endpackage

// File: rtl/ddr_init_mode_enc.sv
module ddr_init_mode_enc #(
    parameter int ADDR_W = 10
) (
    input  logic [2:0]        cas_lat,
    input  logic [3:0]        burst_len,
    input  logic              interleave,
    input  logic              dll_reset,
    output logic [ADDR_W-1:0] opcode
);
    logic [2:0] bl_f;
    logic [2:0] cl_f;

    always_comb begin
        unique case (burst_len)
            4'd2:    bl_f = 3'b001;
            4'd8:    bl_f = 3'b011;
            default: bl_f = 3'b010;
        endcase
        cl_f = (cas_lat == 3'd4) ? 3'b100 : 3'b011;

        opcode      = '0;
        opcode[2:0] = bl_f;
        opcode[3]   = interleave;
        opcode[6:4] = cl_f;
        opcode[7]   = 1'b0;
        opcode[ddr_init_pkg::DLLRST_BIT] = dll_reset;
    end
endmodule

// File: rtl/ddr_init_dll_timer.sv
module ddr_init_dll_timer #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);
    localparam int DW = $clog2(T_DLL + 1);
    localparam logic [DW-1:0] LIMIT = DW'(T_DLL);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = DW'(1);
        else if (cnt_q != '0 && cnt_q != LIMIT)
            cnt_d = cnt_q + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign locked = (cnt_q == LIMIT);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int T_STABLE = 50000,
    parameter int T_MRD    = 2,
    parameter int T_RP     = 4,
    parameter int T_RFC    = 14,
    parameter int T_DLL    = 200,
    parameter int N_REF    = 2,
    parameter int ADDR_W   = 10,
    parameter int BA_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [3:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_busy,
    output logic              init_done,
    output logic              rd_ok
);
    localparam int M1    = (T_STABLE > T_RFC) ? T_STABLE : T_RFC;
    localparam int M2    = (M1 > T_RP) ? M1 : T_RP;
    localparam int T_MAX = (M2 > T_MRD) ? M2 : T_MRD;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int REF_W = $clog2(N_REF + 1);

    localparam logic [CNT_W-1:0] LD_STB = CNT_W'(T_STABLE - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF);
    localparam logic [BA_W-1:0]  BA_EXT   = BA_W'(1);

    typedef struct packed {
        seq_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [REF_W-1:0]    nref;
        logic                cke;
        logic [3:0]          cmd;
        logic [BA_W-1:0]     ba;
        logic [ADDR_W-1:0]   addr;
        logic                busy;
        logic                done;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_STABLE, cnt: '0, nref: '0, cke: 1'b0, cmd: CMD_NOP,
        ba: '0, addr: '0, busy: 1'b1, done: 1'b0
    };

    seq_regs_t d, q;

    // Mode words: index 0 with loop reset cleared, index 1 with it set
    logic [ADDR_W-1:0] mode_op [2];

    for (genvar g = 0; g < 2; g++) begin : g_mode
        ddr_init_mode_enc #(.ADDR_W(ADDR_W)) u_enc (
            .cas_lat    (cfg_cas_lat),
            .burst_len  (cfg_burst_len),
            .interleave (cfg_interleave),
            .dll_reset  (g == 1),
            .opcode     (mode_op[g])
        );
    end

    logic dll_locked;

    ddr_init_dll_timer #(.T_DLL(T_DLL)) u_dll (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (q.st == ST_MR_RST),
        .locked (dll_locked)
    );

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.ba   = '0;
        d.addr = '0;
        unique case (q.st)
            ST_STABLE: begin
                if (q.cnt == LD_STB) begin
                    d.st  = ST_CKE_UP;
                    d.cnt = '0;
                    d.cke = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_CKE_UP: begin
                d.st   = ST_PRE_A;
                d.cmd  = CMD_PRE;
                d.addr[ALLBANK_BIT] = 1'b1;
            end
            ST_PRE_A: begin
                d.st  = ST_PRE_A_W;
                d.cnt = LD_RP;
            end
            ST_PRE_A_W: begin
                if (q.cnt == '0) begin
                    d.st  = ST_EMR;
                    d.cmd = CMD_MRS;
                    d.ba  = BA_EXT;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_EMR: begin
                d.st  = ST_EMR_W;
                d.cnt = LD_MRD;
            end
            ST_EMR_W: begin
                if (q.cnt == '0) begin
                    d.st   = ST_MR_RST;
                    d.cmd  = CMD_MRS;
                    d.addr = mode_op[1];
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_MR_RST: begin
                d.st  = ST_MR_RST_W;
                d.cnt = LD_MRD;
            end
            ST_MR_RST_W: begin
                if (q.cnt == '0) begin
                    d.st   = ST_PRE_B;
                    d.cmd  = CMD_PRE;
                    d.addr[ALLBANK_BIT] = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_PRE_B: begin
                d.st  = ST_PRE_B_W;
                d.cnt = LD_RP;
            end
            ST_PRE_B_W: begin
                if (q.cnt == '0) begin
                    d.st   = ST_REF;
                    d.cmd  = CMD_REF;
                    d.nref = '0;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_REF: begin
                d.st   = ST_REF_W;
                d.cnt  = LD_RFC;
                d.nref = q.nref + REF_W'(1);
            end
            ST_REF_W: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else if (q.nref == REF_LAST) begin
                    d.st   = ST_MR_RUN;
                    d.cmd  = CMD_MRS;
                    d.addr = mode_op[0];
                end else begin
                    d.st  = ST_REF;
                    d.cmd = CMD_REF;
                end
            end
            ST_MR_RUN: begin
                d.st  = ST_MR_RUN_W;
                d.cnt = LD_MRD;
            end
            ST_MR_RUN_W: begin
                if (q.cnt == '0) begin
                    d.st   = ST_READY;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_READY: begin
                d.st = ST_READY;
            end
            default: begin
                d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign mem_cke   = q.cke;
    assign mem_cs_n  = q.cmd[3];
    assign mem_ras_n = q.cmd[2];
    assign mem_cas_n = q.cmd[1];
    assign mem_we_n  = q.cmd[0];
    assign mem_ba    = q.ba;
    assign mem_addr  = q.addr;
    assign init_busy = q.busy;
    assign init_done = q.done;
    assign rd_ok     = q.done & dll_locked;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int T_MRD  = 2,
    parameter int T_RP   = 4,
    parameter int T_RFC  = 14,
    parameter int T_DLL  = 200,
    parameter int ADDR_W = 10,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cke,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BA_W-1:0]   mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_busy,
    input logic              init_done,
    input logic              rd_ok
);
    localparam int DW = $clog2(T_DLL + 1);

    logic [3:0]  cmd;
    logic        is_cmd;
    logic        is_mrs;
    logic        seen_q;
    logic [15:0] since_q;
    logic [15:0] req_q;
    logic        dll_armed_q;
    logic [DW-1:0] dll_cnt_q;

    assign cmd    = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign is_cmd = (cmd != ddr_init_pkg::CMD_NOP);
    assign is_mrs = (cmd == ddr_init_pkg::CMD_MRS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
            req_q   <= '0;
        end else if (is_cmd) begin
            seen_q  <= 1'b1;
            since_q <= '0;
            req_q   <= (cmd == ddr_init_pkg::CMD_PRE) ? 16'(T_RP) :
                       (cmd == ddr_init_pkg::CMD_REF) ? 16'(T_RFC) : 16'(T_MRD);
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_armed_q <= 1'b0;
            dll_cnt_q   <= '0;
        end else if (is_mrs && mem_ba == '0 && mem_addr[ddr_init_pkg::DLLRST_BIT]) begin
            dll_armed_q <= 1'b1;
            dll_cnt_q   <= DW'(1);
        end else if (dll_armed_q && dll_cnt_q != DW'(T_DLL)) begin
            dll_cnt_q   <= dll_cnt_q + DW'(1);
        end
    end

    AST_QUIET_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cke |-> (cmd == ddr_init_pkg::CMD_NOP)) else $error("bus active with cke low"); // R1

    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cke |=> mem_cke) else $error("cke dropped"); // R2

    AST_MRS_AFTER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> $past(mem_cke)) else $error("mode write without prior cke"); // R2

    AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_q) |-> (since_q >= req_q)) else $error("command gap too short"); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done) else $error("done dropped"); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!is_cmd && mem_cke && !init_busy)) else $error("activity after done"); // R9

    AST_RD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> init_done) else $error("read permission before done"); // R10

    AST_RD_LOCK_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (dll_armed_q && dll_cnt_q == DW'(T_DLL))) else $error("read permission before lock time"); // R10

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .T_MRD  (T_MRD),
    .T_RP   (T_RP),
    .T_RFC  (T_RFC),
    .T_DLL  (T_DLL),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .init_busy (init_busy),
    .init_done (init_done),
    .rd_ok     (rd_ok)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
    localparam int TB_STABLE = 300;
    localparam int TB_MRD    = 2;
    localparam int TB_RP     = 4;
    localparam int TB_RFC    = 14;
    localparam int TB_DLL    = 200;
    localparam int NOP_C     = 4'b0111;
    localparam int PRE_C     = 4'b0010;
    localparam int REF_C     = 4'b0001;
    localparam int MRS_C     = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_cas_lat = 3'd3;
    logic [3:0] cfg_burst_len = 4'd4;
    logic       cfg_interleave = 1'b0;
    logic       mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0] mem_ba;
    logic [9:0] mem_addr;
    logic       init_busy, init_done, rd_ok;

    int n_checks = 0;
    int n_errors = 0;
    int wd = 0;

    always #2 clk = ~clk;

    ddr_init_seq #(
        .T_STABLE (TB_STABLE),
        .T_MRD    (TB_MRD),
        .T_RP     (TB_RP),
        .T_RFC    (TB_RFC),
        .T_DLL    (TB_DLL)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_cas_lat    (cfg_cas_lat),
        .cfg_burst_len  (cfg_burst_len),
        .cfg_interleave (cfg_interleave),
        .mem_cke        (mem_cke),
        .mem_cs_n       (mem_cs_n),
        .mem_ras_n      (mem_ras_n),
        .mem_cas_n      (mem_cas_n),
        .mem_we_n       (mem_we_n),
        .mem_ba         (mem_ba),
        .mem_addr       (mem_addr),
        .init_busy      (init_busy),
        .init_done      (init_done),
        .rd_ok          (rd_ok)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL R3 watchdog: actual %0d expected <= %0d cycles", wd, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cl(input int cl);
        return (cl == 4) ? 3'b100 : 3'b011;
    endfunction

    function automatic int exp_bl(input int bl);
        if (bl == 2) return 3'b001;
        if (bl == 8) return 3'b011;
        return 3'b010;
    endfunction

    function automatic int exp_mr(input int cl, input int bl, input int bt, input int rst);
        return (rst << 8) | (exp_cl(cl) << 4) | (bt << 3) | exp_bl(bl);
    endfunction

    function automatic int gap_of(input int code);
        if (code == PRE_C) return TB_RP;
        if (code == REF_C) return TB_RFC;
        return TB_MRD;
    endfunction

    function automatic int cur_cmd();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    task automatic run_one(input int cl, input int bl, input int bt);
        int c_code [16];
        int c_ba   [16];
        int c_addr [16];
        int c_cyc  [16];
        int exp_code [7];
        int n_cmd = 0;
        int cke_rise = -1;
        int low_active = 0;
        int cke_drop = 0;
        int done_cyc = -1;
        int rd_cyc = -1;
        int busy_bad = 0;
        int post_done_bad = 0;
        int done_drop = 0;
        int rd_drop = 0;
        bit reserved;
        string tag;

        exp_code = '{PRE_C, MRS_C, MRS_C, PRE_C, REF_C, REF_C, MRS_C};
        reserved = !(cl == 3 || cl == 4) || !(bl == 2 || bl == 4 || bl == 8);
        tag = reserved ? "R7" : "R6";

        cfg_cas_lat    = 3'(cl);
        cfg_burst_len  = 4'(bl);
        cfg_interleave = 1'(bt);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_cke == 1'b0, "R1", "cke in reset", int'(mem_cke), 0);
        chk(cur_cmd() == NOP_C, "R1", "command in reset", cur_cmd(), NOP_C);
        chk(init_busy && !init_done && !rd_ok, "R1", "flags in reset",
            {init_busy, init_done, rd_ok}, 3'b100);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int cyc = 0; cyc < TB_STABLE + 2000; cyc++) begin
            @(negedge clk);
            if (mem_cke && cke_rise < 0) cke_rise = cyc;
            if (!mem_cke && cke_rise >= 0) cke_drop++;
            if (!mem_cke && cur_cmd() != NOP_C) low_active++;
            if (init_busy == init_done) busy_bad++;
            if (done_cyc >= 0 && !init_done) done_drop++;
            if (rd_cyc >= 0 && !rd_ok) rd_drop++;
            if (init_done && (cur_cmd() != NOP_C || !mem_cke)) post_done_bad++;
            if (init_done && done_cyc < 0) done_cyc = cyc;
            if (rd_ok && rd_cyc < 0) rd_cyc = cyc;
            if (cur_cmd() != NOP_C) begin
                if (n_cmd < 16) begin
                    c_code[n_cmd] = cur_cmd();
                    c_ba[n_cmd]   = int'(mem_ba);
                    c_addr[n_cmd] = int'(mem_addr);
                    c_cyc[n_cmd]  = cyc;
                end
                n_cmd++;
            end
            if (rd_cyc >= 0 && cyc > rd_cyc + 20) break;
        end

        chk(cke_rise == TB_STABLE, "R1", "cke low cycles", cke_rise, TB_STABLE);
        chk(low_active == 0, "R1", "commands while cke low", low_active, 0);
        chk(cke_drop == 0, "R2", "cke drops", cke_drop, 0);
        chk(n_cmd == 7, "R3", "command count", n_cmd, 7);
        if (n_cmd == 7) begin
            for (int i = 0; i < 7; i++)
                chk(c_code[i] == exp_code[i], "R3", "command code", c_code[i], exp_code[i]);
            chk(c_cyc[0] == cke_rise + 1, "R8", "first precharge cycle", c_cyc[0], cke_rise + 1);
            chk(c_cyc[1] > cke_rise, "R2", "cke before mode write", c_cyc[1], cke_rise + 1);
            chk(c_addr[0][8] == 1, "R4", "first precharge a8", c_addr[0][8], 1);
            chk(c_addr[3][8] == 1, "R4", "second precharge a8", c_addr[3][8], 1);
            chk(c_ba[1] == 1, "R5", "ext mode bank", c_ba[1], 1);
            chk(c_addr[1] == 0, "R5", "ext mode word", c_addr[1], 0);
            chk(c_ba[2] == 0 && c_ba[6] == 0, "R6", "mode bank", c_ba[2] + c_ba[6], 0);
            chk(c_addr[2] == exp_mr(cl, bl, bt, 1), tag, "reset mode word",
                c_addr[2], exp_mr(cl, bl, bt, 1));
            chk(c_addr[6] == exp_mr(cl, bl, bt, 0), tag, "final mode word",
                c_addr[6], exp_mr(cl, bl, bt, 0));
            for (int i = 0; i < 6; i++)
                chk(c_cyc[i+1] - c_cyc[i] - 1 == gap_of(c_code[i]), "R8", "nop gap",
                    c_cyc[i+1] - c_cyc[i] - 1, gap_of(c_code[i]));
            chk(done_cyc == c_cyc[6] + TB_MRD + 1, "R9", "done cycle",
                done_cyc, c_cyc[6] + TB_MRD + 1);
            chk(rd_cyc == ((done_cyc > c_cyc[2] + TB_DLL) ? done_cyc : c_cyc[2] + TB_DLL),
                "R10", "read permission cycle", rd_cyc,
                (done_cyc > c_cyc[2] + TB_DLL) ? done_cyc : c_cyc[2] + TB_DLL);
        end
        chk(busy_bad == 0, "R9", "busy not inverse of done", busy_bad, 0);
        chk(post_done_bad == 0 && done_drop == 0, "R9", "activity or drop after done",
            post_done_bad + done_drop, 0);
        chk(rd_drop == 0, "R10", "read permission drops", rd_drop, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_one(3, 4, 0);
        run_one(4, 8, 1);
        run_one(3, 2, 1);
        run_one(5, 16, 0);   // R7 reserved latency and length
        run_one(0, 3, 1);    // R7 reserved values
        // reset taken partway through the sequence, then a full run
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (TB_STABLE + 40) @(posedge clk);
        run_one(4, 2, 0);
        for (int k = 0; k < 4; k++) begin
            int cl;
            int bl;
            int bt;
            cl = ($urandom % 4 == 0) ? int'($urandom % 8) : 3 + int'($urandom % 2);
            bl = ($urandom % 4 == 0) ? int'($urandom % 16) : (2 << ($urandom % 3));
            bt = int'($urandom % 2);
            run_one(cl, bl, bt);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule